// File: doc/BRIEF.md
# Hash Run Sequencer with Per-Run Block Limit

This controller walks a 512-bit-state, 1024-bit-block hash compression engine across a message stored in a memory of 64-bit words. A start strobe hands it a message address, a byte count, the address of a parameter area and a mode flag that selects intermediate or final processing. It fetches the chaining value from the parameter area, then fetches each full 128-byte block, hands it to the external compression engine and keeps the new chaining value. It writes the final chaining value back to the parameter area and then reports the advanced address, the reduced length and a 2-bit completion code.

A run stops after a fixed number of blocks. Software sees completion code 3 and issues the run again with the returned address and length. In final mode, a tail shorter than one block goes to an external padding engine, which returns the closing chaining value. In intermediate mode, a length that is not block-aligned is refused before any memory access. A 2-bit addressing-mode input limits address advance to 24, 32 or all bits. In the 24-bit and 32-bit modes the length is taken as 32 bits.

Top module: `hash_run_seq`

## Requirements
- R1: With `last_i`=0 and an effective length whose low 7 bits are not zero, the run ends with `fault_o`=1. No memory read or write takes place and neither engine is started. `addr_o` and `len_o` equal the inputs and `cc_o`=0.
- R2: A run starts the compression engine at most `MAX_BLOCKS` (64) times. A run that stops with 128 or more bytes still unprocessed ends with `cc_o`=3.
- R3: Before any message word is fetched, the eight chaining words are read from addresses parameter+8*i, in order i=0..7.
- R4: Exactly eight write-back words go to parameter+8*i, in order i=0..7. No read follows the first write. `addr_o` and `len_o` do not change while `busy_o` is high, and they take their new values in the same cycle as `done_o`.
- R5: `addr_o` is the message address advanced by the processed byte count. `len_o` is `msg_len_i` minus the processed byte count, computed over all `LW` bits.
- R6: `done_o` is a single-cycle pulse. At that pulse `cc_o` is 0 when the effective length is fully consumed and 3 otherwise.
- R7: `mode_i` encodes 0 = 24-bit, 1 = 32-bit, 2 or 3 = full-width. In the 24-bit and 32-bit modes only the low 24 or 32 address bits take the carry, the upper bits stay as given, and only the low 32 bits of the length count.
- R8: `busy_o` rises the cycle after an accepted start and stays high until `done_o`. A start while `busy_o` is high is ignored. After reset `busy_o`, `done_o`, `cc_o` and `addr_o` are zero.
- R9: With `last_i`=1, once fewer than 128 bytes remain, the padding engine is started exactly once. It receives the tail address and a tail byte count of 0..127, its chaining value is written back and the tail counts as processed.
- R10: Memory data returns one cycle after `rd_en_o`. Chaining word i is carried on bits [64*i+63:64*i] of `chain_o`, `cmp_cv_i` and `pad_cv_i`. Block word i, read from block address+8*i, is on bits [64*i+63:64*i] of `cmp_blk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run start strobe |
| last_i | input | 1 | 1 = final mode (tail padded), 0 = intermediate |
| mode_i | input | 2 | Addressing mode: 0 = 24-bit, 1 = 32-bit, 2/3 = full |
| msg_addr_i | input | AW | Message start byte address |
| msg_len_i | input | LW | Message length in bytes |
| param_addr_i | input | AW | Parameter area address |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Misaligned intermediate length refused |
| cc_o | output | 2 | Completion code: 0 finished, 3 partial |
| addr_o | output | AW | Advanced message address |
| len_o | output | LW | Remaining length |
| rd_en_o | output | 1 | Memory read request |
| rd_addr_o | output | AW | Memory read byte address |
| rd_data_i | input | 64 | Read data, one cycle after request |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | AW | Memory write byte address |
| wr_data_o | output | 64 | Memory write data |
| chain_o | output | 512 | Current chaining value for both engines |
| cmp_start_o | output | 1 | Compression engine start |
| cmp_blk_o | output | 1024 | Message block for compression |
| cmp_done_i | input | 1 | Compression finished |
| cmp_cv_i | input | 512 | Chaining value after compression |
| pad_start_o | output | 1 | Padding engine start |
| pad_addr_o | output | AW | Tail start address |
| pad_bytes_o | output | 7 | Tail byte count |
| pad_done_i | input | 1 | Padding finished |
| pad_cv_i | input | 512 | Chaining value after padding |

## Verification
The bench builds the block with its default parameters: 64-bit address and length, 16-word blocks and a limit of 64 blocks per run. The full address width lets all three addressing modes carry across bit 24 and bit 32 with upper bits that must survive. The limit of 64 blocks costs only about 1,500 cycles per run, so messages of 64 and 65 blocks, with and without a tail, show both the stop with code 3 and the re-issue that follows it. Final-mode tails of 0, 111, 112 and 127 bytes exercise the padding hand-off at its edges.

// File: rtl/hr_pkg.sv
package hr_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_CV_RD, ST_DECIDE, ST_BLK_RD, ST_CMP_GO, ST_CMP_WAIT,
      ST_PAD_GO, ST_PAD_WAIT, ST_WB, ST_DONE
   } hr_state_e;

   localparam logic [1:0] AM_24   = 2'd0;
   localparam logic [1:0] AM_32   = 2'd1;
   localparam logic [1:0] CC_ALL  = 2'd0;
   localparam logic [1:0] CC_PART = 2'd3;
endpackage

// File: rtl/hr_addr_step.sv
module hr_addr_step import hr_pkg::*; #(
   parameter int AW = 64
) (
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] off_i,
   input  logic [1:0]    mode_i,
   output logic [AW-1:0] addr_o
);
   logic [AW-1:0] sum;
   assign sum = base_i + off_i;

   if (AW < 32) begin : g_bad_width
      $error("hr_addr_step: AW must be at least 32");
   end else if (AW > 32) begin : g_wide
      always_comb begin
         if (mode_i == AM_24)      addr_o = {base_i[AW-1:24], sum[23:0]};
         else if (mode_i == AM_32) addr_o = {base_i[AW-1:32], sum[31:0]};
         else                      addr_o = sum;
      end
   end else begin : g_narrow
      always_comb begin
         if (mode_i == AM_24) addr_o = {base_i[AW-1:24], sum[23:0]};
         else                 addr_o = sum;
      end
   end
endmodule

// File: rtl/hr_word_sink.sv
module hr_word_sink #(
   parameter int  WORDS = 16,
   parameter int  DW    = 64,
   localparam int IW    = $clog2(WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [IW-1:0]       idx_i,
   input  logic [DW-1:0]       data_i,
   output logic [WORDS*DW-1:0] flat_o
);
   logic [DW-1:0] word_q [WORDS];

   if (WORDS < 2) begin : g_bad_depth
      $error("hr_word_sink: WORDS must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) word_q[w] <= '0;
      end else if (we_i) begin
         for (int w = 0; w < WORDS; w++)
            if (idx_i == IW'(w)) word_q[w] <= data_i;
      end
   end

   for (genvar g = 0; g < WORDS; g++) begin : g_flat
      assign flat_o[g*DW +: DW] = word_q[g];
   end
endmodule

// File: rtl/hash_run_seq.sv
module hash_run_seq import hr_pkg::*; #(
   parameter int  AW         = 64,
   parameter int  LW         = 64,
   parameter int  CV_WORDS   = 8,
   parameter int  BLK_WORDS  = 16,
   parameter int  MAX_BLOCKS = 64,
   localparam int DW         = 64,
   localparam int BLK_BYTES  = BLK_WORDS * (DW / 8),
   localparam int PBW        = $clog2(BLK_BYTES),
   localparam int CVW        = CV_WORDS * DW,
   localparam int BKW        = BLK_WORDS * DW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            last_i,
   input  logic [1:0]      mode_i,
   input  logic [AW-1:0]   msg_addr_i,
   input  logic [LW-1:0]   msg_len_i,
   input  logic [AW-1:0]   param_addr_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            fault_o,
   output logic [1:0]      cc_o,
   output logic [AW-1:0]   addr_o,
   output logic [LW-1:0]   len_o,
   output logic            rd_en_o,
   output logic [AW-1:0]   rd_addr_o,
   input  logic [DW-1:0]   rd_data_i,
   output logic            wr_en_o,
   output logic [AW-1:0]   wr_addr_o,
   output logic [DW-1:0]   wr_data_o,
   output logic [CVW-1:0]  chain_o,
   output logic            cmp_start_o,
   output logic [BKW-1:0]  cmp_blk_o,
   input  logic            cmp_done_i,
   input  logic [CVW-1:0]  cmp_cv_i,
   output logic            pad_start_o,
   output logic [AW-1:0]   pad_addr_o,
   output logic [PBW-1:0]  pad_bytes_o,
   input  logic            pad_done_i,
   input  logic [CVW-1:0]  pad_cv_i
);
   localparam int CW  = $clog2(BLK_WORDS + 1);
   localparam int CIW = $clog2(CV_WORDS);
   localparam int BIW = $clog2(BLK_WORDS);
   localparam int BCW = $clog2(MAX_BLOCKS + 1);

   if ((BLK_WORDS & (BLK_WORDS - 1)) != 0 || BLK_WORDS < 2) begin : g_bad_blk
      $error("hash_run_seq: BLK_WORDS must be a power of two");
   end
   if (CV_WORDS < 2 || CV_WORDS > BLK_WORDS) begin : g_bad_cv
      $error("hash_run_seq: CV_WORDS must lie in 2..BLK_WORDS");
   end
   if (LW < 32 || MAX_BLOCKS < 1) begin : g_bad_len
      $error("hash_run_seq: LW >= 32 and MAX_BLOCKS >= 1 required");
   end

   hr_state_e      state_q;
   logic [CW-1:0]  cnt_q, cap_idx_q, n_words;
   logic           cap_v_q, cap_last;
   logic [BCW-1:0] blk_q;
   logic [LW-1:0]  done_bytes_q, len_q, eff_len, eff_in, remain;
   logic [AW-1:0]  msg_q, param_q, step_base, step_off, word_off, mem_addr, run_addr;
   logic [1:0]     mode_q;
   logic           last_q, accept, more_blocks, short_tail;
   logic [DW-1:0]  cv_q [CV_WORDS];

   // effective length: 32-bit view in the narrow addressing modes
   assign eff_len = (mode_q == AM_24 || mode_q == AM_32) ? LW'(len_q[31:0]) : len_q;
   assign eff_in  = (mode_i == AM_24 || mode_i == AM_32) ? LW'(msg_len_i[31:0]) : msg_len_i;
   assign remain  = eff_len - done_bytes_q;

   assign busy_o  = (state_q != ST_IDLE) && (state_q != ST_DONE);
   assign done_o  = (state_q == ST_DONE);
   assign accept  = start_i && !busy_o;

   assign n_words  = (state_q == ST_CV_RD) ? CW'(CV_WORDS) : CW'(BLK_WORDS);
   assign rd_en_o  = (state_q == ST_CV_RD || state_q == ST_BLK_RD) && (cnt_q != n_words);
   assign cap_last = cap_v_q && (cap_idx_q == n_words - CW'(1));

   assign more_blocks = (remain >= LW'(BLK_BYTES)) && (blk_q < BCW'(MAX_BLOCKS));
   assign short_tail  = (remain < LW'(BLK_BYTES));

   // one shared address step for parameter-area and block words
   assign word_off  = AW'({cnt_q, 3'b000});
   assign step_base = (state_q == ST_BLK_RD) ? msg_q : param_q;
   assign step_off  = (state_q == ST_BLK_RD) ? AW'(done_bytes_q) + word_off : word_off;

   hr_addr_step #(.AW(AW)) u_mem_step (
      .base_i(step_base), .off_i(step_off), .mode_i(mode_q), .addr_o(mem_addr)
   );
   hr_addr_step #(.AW(AW)) u_run_step (
      .base_i(msg_q), .off_i(AW'(done_bytes_q)), .mode_i(mode_q), .addr_o(run_addr)
   );

   hr_word_sink #(.WORDS(BLK_WORDS), .DW(DW)) u_blk (
      .clk(clk), .rst_n(rst_n),
      .we_i(cap_v_q && state_q == ST_BLK_RD),
      .idx_i(cap_idx_q[BIW-1:0]),
      .data_i(rd_data_i),
      .flat_o(cmp_blk_o)
   );

   assign rd_addr_o   = mem_addr;
   assign wr_addr_o   = mem_addr;
   assign wr_en_o     = (state_q == ST_WB);
   assign wr_data_o   = cv_q[cnt_q[CIW-1:0]];
   assign cmp_start_o = (state_q == ST_CMP_GO);
   assign pad_start_o = (state_q == ST_PAD_GO);
   assign pad_addr_o  = run_addr;
   assign pad_bytes_o = remain[PBW-1:0];

   for (genvar g = 0; g < CV_WORDS; g++) begin : g_chain
      assign chain_o[g*DW +: DW] = cv_q[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cnt_q        <= '0;
         cap_v_q      <= 1'b0;
         cap_idx_q    <= '0;
         blk_q        <= '0;
         done_bytes_q <= '0;
         msg_q        <= '0;
         param_q      <= '0;
         len_q        <= '0;
         mode_q       <= '0;
         last_q       <= 1'b0;
         fault_o      <= 1'b0;
         cc_o         <= CC_ALL;
         addr_o       <= '0;
         len_o        <= '0;
         for (int w = 0; w < CV_WORDS; w++) cv_q[w] <= '0;
      end else begin
         cap_v_q   <= rd_en_o;
         cap_idx_q <= cnt_q;
         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (accept) begin
                  msg_q   <= msg_addr_i;
                  param_q <= param_addr_i;
                  len_q   <= msg_len_i;
                  mode_q  <= mode_i;
                  last_q  <= last_i;
                  if (!last_i && eff_in[PBW-1:0] != '0) begin
                     addr_o  <= msg_addr_i;
                     len_o   <= msg_len_i;
                     fault_o <= 1'b1;
                     cc_o    <= CC_ALL;
                     state_q <= ST_DONE;
                  end else begin
                     fault_o      <= 1'b0;
                     cnt_q        <= '0;
                     blk_q        <= '0;
                     done_bytes_q <= '0;
                     state_q      <= ST_CV_RD;
                  end
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_CV_RD: begin
               if (rd_en_o) cnt_q <= cnt_q + CW'(1);
               if (cap_v_q) cv_q[cap_idx_q[CIW-1:0]] <= rd_data_i;
               if (cap_last) state_q <= ST_DECIDE;
            end
            ST_DECIDE: begin
               cnt_q <= '0;
               if (more_blocks)                  state_q <= ST_BLK_RD;
               else if (last_q && short_tail)    state_q <= ST_PAD_GO;
               else                              state_q <= ST_WB;
            end
            ST_BLK_RD: begin
               if (rd_en_o) cnt_q <= cnt_q + CW'(1);
               if (cap_last) state_q <= ST_CMP_GO;
            end
            ST_CMP_GO: state_q <= ST_CMP_WAIT;
            ST_CMP_WAIT: begin
               if (cmp_done_i) begin
                  for (int w = 0; w < CV_WORDS; w++) cv_q[w] <= cmp_cv_i[w*DW +: DW];
                  blk_q        <= blk_q + BCW'(1);
                  done_bytes_q <= done_bytes_q + LW'(BLK_BYTES);
                  state_q      <= ST_DECIDE;
               end
            end
            ST_PAD_GO: state_q <= ST_PAD_WAIT;
            ST_PAD_WAIT: begin
               if (pad_done_i) begin
                  for (int w = 0; w < CV_WORDS; w++) cv_q[w] <= pad_cv_i[w*DW +: DW];
                  done_bytes_q <= eff_len;
                  cnt_q        <= '0;
                  state_q      <= ST_WB;
               end
            end
            ST_WB: begin
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == CW'(CV_WORDS - 1)) begin
                  addr_o  <= run_addr;
                  len_o   <= len_q - done_bytes_q;
                  cc_o    <= (remain == '0) ? CC_ALL : CC_PART;
                  state_q <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hr_run_chk.sv
module hr_run_chk #(
   parameter int CV_WORDS   = 8,
   parameter int MAX_BLOCKS = 64,
   parameter int AW         = 64,
   parameter int LW         = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          fault_o,
   input logic [1:0]    cc_o,
   input logic          rd_en_o,
   input logic          wr_en_o,
   input logic          cmp_start_o,
   input logic          pad_start_o,
   input logic [AW-1:0] addr_o,
   input logic [LW-1:0] len_o
);
   logic [15:0] n_rd, n_wr, n_cmp, n_pad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_rd <= '0; n_wr <= '0; n_cmp <= '0; n_pad <= '0;
      end else if (start_i && !busy_o) begin
         n_rd <= '0; n_wr <= '0; n_cmp <= '0; n_pad <= '0;
      end else begin
         if (rd_en_o)     n_rd  <= n_rd + 16'd1;
         if (wr_en_o)     n_wr  <= n_wr + 16'd1;
         if (cmp_start_o) n_cmp <= n_cmp + 16'd1;
         if (pad_start_o) n_pad <= n_pad + 16'd1;
      end
   end

   a_r1_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o |-> n_rd == 16'd0 && n_wr == 16'd0 && n_cmp == 16'd0 && n_pad == 16'd0);
   a_r2_block_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_start_o |-> n_cmp < 16'(MAX_BLOCKS));
   a_r3_cv_first: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_start_o |-> n_rd >= 16'(CV_WORDS));
   a_r4_no_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> n_wr == 16'd0);
   a_r4_full_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !fault_o |-> n_wr == 16'(CV_WORDS));
   a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> $stable(addr_o) && $stable(len_o));
   a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> cc_o == 2'd0 || cc_o == 2'd3);
   a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   a_r8_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o || done_o);
   a_r9_single_pad: assert property (@(posedge clk) disable iff (!rst_n)
      pad_start_o |-> n_pad == 16'd0);
endmodule

bind hash_run_seq hr_run_chk #(
   .CV_WORDS(CV_WORDS), .MAX_BLOCKS(MAX_BLOCKS), .AW(AW), .LW(LW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
   .fault_o(fault_o), .cc_o(cc_o), .rd_en_o(rd_en_o), .wr_en_o(wr_en_o),
   .cmp_start_o(cmp_start_o), .pad_start_o(pad_start_o), .addr_o(addr_o), .len_o(len_o)
);

// File: tb/hash_run_seq_tb.sv
module hash_run_seq_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          start, last, busy, done, fault, rd_en, wr_en;
   logic          cmp_start, cmp_done, pad_start, pad_done;
   logic [1:0]    mode, cc;
   logic [63:0]   msg_addr, msg_len, param_addr, addr_o, len_o;
   logic [63:0]   rd_addr, rd_data, wr_addr, wr_data, pad_addr;
   logic [511:0]  chain, cmp_cv, pad_cv;
   logic [1023:0] blk;
   logic [6:0]    pad_bytes;

   hash_run_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .last_i(last), .mode_i(mode),
      .msg_addr_i(msg_addr), .msg_len_i(msg_len), .param_addr_i(param_addr),
      .busy_o(busy), .done_o(done), .fault_o(fault), .cc_o(cc), .addr_o(addr_o),
      .len_o(len_o), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .chain_o(chain),
      .cmp_start_o(cmp_start), .cmp_blk_o(blk), .cmp_done_i(cmp_done), .cmp_cv_i(cmp_cv),
      .pad_start_o(pad_start), .pad_addr_o(pad_addr), .pad_bytes_o(pad_bytes),
      .pad_done_i(pad_done), .pad_cv_i(pad_cv)
   );

   function automatic logic [63:0] mem_word(input logic [63:0] a);
      return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0000_0005_DEEC_E66D;
   endfunction

   function automatic logic [63:0] wrap_add(input logic [63:0] b, input logic [63:0] o,
                                            input logic [1:0] m);
      logic [63:0] mask;
      mask = (m == 2'd0) ? 64'h00FF_FFFF : (m == 2'd1) ? 64'hFFFF_FFFF : '1;
      return (b & ~mask) | ((b + o) & mask);
   endfunction

   function automatic logic [511:0] cmp_fn(input logic [511:0] cv, input logic [1023:0] b);
      logic [511:0] r;
      for (int i = 0; i < 8; i++)
         r[64*i +: 64] = (cv[64*i +: 64] ^ b[128*i +: 64]) + b[128*i+64 +: 64] + 64'(i);
      return r;
   endfunction

   function automatic logic [511:0] pad_fn(input logic [511:0] cv, input logic [63:0] a,
                                           input logic [6:0] n);
      logic [511:0] r;
      for (int i = 0; i < 8; i++)
         r[64*i +: 64] = (cv[64*i +: 64] + a * 64'(i + 1)) ^ {57'd0, n};
      return r;
   endfunction

   // memory and engine models
   logic [3:0] cmp_wait, pad_wait;
   always @(posedge clk) begin
      if (rd_en) rd_data <= mem_word(rd_addr);
      cmp_done <= 1'b0;
      pad_done <= 1'b0;
      if (cmp_start) cmp_wait <= 4'd3;
      else if (cmp_wait != 0) begin
         cmp_wait <= cmp_wait - 4'd1;
         if (cmp_wait == 4'd1) begin cmp_done <= 1'b1; cmp_cv <= cmp_fn(chain, blk); end
      end
      if (pad_start) pad_wait <= 4'd2;
      else if (pad_wait != 0) begin
         pad_wait <= pad_wait - 4'd1;
         if (pad_wait == 4'd1) begin
            pad_done <= 1'b1; pad_cv <= pad_fn(chain, pad_addr, pad_bytes);
         end
      end
   end

   // monitor
   int          m_rd, m_wr, m_cmp, m_pad;
   logic        rd_late;
   logic [63:0] wa [8], wd [8], ra [8], m_pad_a;
   logic [6:0]  m_pad_n;
   always @(posedge clk) begin
      if (rd_en) begin
         if (m_rd < 8) ra[m_rd] = rd_addr;
         if (m_wr != 0) rd_late = 1'b1;
         m_rd++;
      end
      if (wr_en) begin
         if (m_wr < 8) begin wa[m_wr] = wr_addr; wd[m_wr] = wr_data; end
         m_wr++;
      end
      if (cmp_start) m_cmp++;
      if (pad_start) begin m_pad++; m_pad_n = pad_bytes; m_pad_a = pad_addr; end
   end

   int n_chk = 0, n_bad = 0, cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected=<150000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference results
   logic [511:0] e_cv;
   logic [63:0]  e_addr, e_len, e_pad_a;
   logic [1:0]   e_cc;
   logic         e_fault;
   int           e_cmp, e_pad;
   logic [6:0]   e_pad_n;

   task automatic ref_run(input logic l, input logic [1:0] m, input logic [63:0] a,
                          input logic [63:0] n, input logic [63:0] p);
      logic [63:0]   eff, used;
      logic [1023:0] b;
      eff = (m >= 2'd2) ? n : {32'd0, n[31:0]};
      e_cmp = 0; e_pad = 0; e_fault = 1'b0;
      if (!l && eff[6:0] != 0) begin
         e_fault = 1'b1; e_addr = a; e_len = n; e_cc = 2'd0;
         return;
      end
      for (int i = 0; i < 8; i++) e_cv[64*i +: 64] = mem_word(wrap_add(p, 64'(8*i), m));
      used = 0;
      while (eff - used >= 64'd128 && e_cmp < 64) begin
         for (int j = 0; j < 16; j++)
            b[64*j +: 64] = mem_word(wrap_add(a, used + 64'(8*j), m));
         e_cv = cmp_fn(e_cv, b);
         used += 64'd128;
         e_cmp++;
      end
      if (l && eff - used < 64'd128) begin
         e_pad = 1; e_pad_n = 7'(eff - used); e_pad_a = wrap_add(a, used, m);
         e_cv = pad_fn(e_cv, e_pad_a, e_pad_n);
         used = eff;
      end
      e_addr = wrap_add(a, used, m);
      e_len  = n - used;
      e_cc   = (eff == used) ? 2'd0 : 2'd3;
   endtask

   task automatic do_run(input string lbl, input logic l, input logic [1:0] m,
                         input logic [63:0] a, input logic [63:0] n,
                         input logic [63:0] p, input bit poke);
      int t;
      @(negedge clk);
      m_rd = 0; m_wr = 0; m_cmp = 0; m_pad = 0; rd_late = 1'b0;
      last = l; mode = m; msg_addr = a; msg_len = n; param_addr = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ref_run(l, m, a, n, p);
      if (!e_fault) chk({lbl, " R8 busy after start"}, 64'(busy), 64'd1);
      if (poke) begin
         repeat (4) @(negedge clk);
         last = ~l; msg_len = n + 64'd77; msg_addr = a ^ 64'hFF; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (!done && t < 20000) begin @(negedge clk); t++; end
      chk({lbl, " R6 done reached"}, 64'(done), 64'd1);
      chk({lbl, " R1 fault flag"}, 64'(fault), 64'(e_fault));
      chk({lbl, " R5 address out"}, addr_o, e_addr);
      chk({lbl, " R5 length out"}, len_o, e_len);
      chk({lbl, " R6 completion code"}, 64'(cc), 64'(e_cc));
      if (e_fault) begin
         chk({lbl, " R1 no reads"}, 64'(m_rd), 64'd0);
         chk({lbl, " R1 no writes"}, 64'(m_wr), 64'd0);
         chk({lbl, " R1 no engine"}, 64'(m_cmp + m_pad), 64'd0);
      end else begin
         chk({lbl, " R2 block count"}, 64'(m_cmp), 64'(e_cmp));
         chk({lbl, " R4 write count"}, 64'(m_wr), 64'd8);
         chk({lbl, " R4 read after write"}, 64'(rd_late), 64'd0);
         for (int i = 0; i < 8; i++) begin
            chk($sformatf("%s R3 cv read addr %0d", lbl, i), ra[i], wrap_add(p, 64'(8*i), m));
            chk($sformatf("%s R4 wb addr %0d", lbl, i), wa[i], wrap_add(p, 64'(8*i), m));
            chk($sformatf("%s R10 wb data %0d", lbl, i), wd[i], e_cv[64*i +: 64]);
         end
         chk({lbl, " R9 pad starts"}, 64'(m_pad), 64'(e_pad));
         if (e_pad == 1) begin
            chk({lbl, " R9 pad bytes"}, 64'(m_pad_n), 64'(e_pad_n));
            chk({lbl, " R9 pad addr"}, m_pad_a, e_pad_a);
         end
      end
      @(negedge clk);
      chk({lbl, " R6 done one cycle"}, 64'(done), 64'd0);
   endtask

   initial begin
      logic [63:0] ra_ret, rl_ret;
      void'($urandom(32'd20240611));
      start = 0; last = 0; mode = 2'd2; msg_addr = 0; msg_len = 0; param_addr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 reset busy", 64'(busy), 64'd0);
      chk("R8 reset done", 64'(done), 64'd0);
      chk("R8 reset code", 64'(cc), 64'd0);
      chk("R8 reset addr", addr_o, 64'd0);

      do_run("two blocks", 1'b0, 2'd2, 64'h0000_1000_0000_0000, 64'd256, 64'h8000, 0);
      do_run("R1 misaligned", 1'b0, 2'd2, 64'h4000, 64'd200, 64'h8000, 0);
      do_run("empty intermediate", 1'b0, 2'd2, 64'h4000, 64'd0, 64'h9000, 0);
      do_run("R9 tail 0", 1'b1, 2'd2, 64'h4000, 64'd0, 64'h9000, 0);
      do_run("R9 tail 111", 1'b1, 2'd2, 64'h4000, 64'd111, 64'h9000, 0);
      do_run("R9 tail 112", 1'b1, 2'd2, 64'h4000, 64'd112, 64'h9000, 0);
      do_run("R9 tail 127", 1'b1, 2'd2, 64'h4000, 64'd127, 64'h9000, 0);
      do_run("R9 block plus 5", 1'b1, 2'd2, 64'h4000, 64'd133, 64'h9000, 0);
      do_run("R2 limit 65", 1'b0, 2'd2, 64'h10_0000, 64'd8320, 64'hA000, 0);
      ra_ret = addr_o; rl_ret = len_o;
      do_run("R2 reissue", 1'b0, 2'd2, ra_ret, rl_ret, 64'hA000, 0);
      do_run("R2 last 64 plus 10", 1'b1, 2'd2, 64'h20_0000, 64'd8202, 64'hA000, 0);
      do_run("R2 last 65 plus 10", 1'b1, 2'd2, 64'h20_0000, 64'd8330, 64'hA000, 0);
      do_run("R7 wrap 24", 1'b0, 2'd0, 64'hAAAA_0000_00FF_FF80, 64'd256, 64'h00FF_FFF0, 0);
      do_run("R7 wrap 32", 1'b1, 2'd1, 64'h5555_0000_FFFF_FF40, 64'hFFFF_0000_0000_0105,
             64'h1234_0000_0000_2000, 0);
      do_run("R7 misaligned upper", 1'b0, 2'd1, 64'h4000, 64'hFFFF_0000_0000_0100, 64'h9000, 0);
      do_run("R8 start while busy", 1'b0, 2'd2, 64'h3000, 64'd384, 64'h9000, 1);

      for (int k = 0; k < 30; k++) begin
         logic        l;
         logic [1:0]  m;
         logic [63:0] a, n, p;
         l = 1'($urandom % 2);
         m = 2'($urandom % 4);
         n = 64'($urandom_range(0, 5)) * 64'd128;
         if (l || ($urandom % 6 == 0)) n += 64'($urandom_range(0, 127));
         if (m < 2 && ($urandom % 2 == 1)) n[63:32] = $urandom;
         a = {$urandom, $urandom};
         if (m == 2'd0 && ($urandom % 2 == 1)) a[23:0] = 24'hFFFE00 + 24'($urandom % 256);
         p = {$urandom, $urandom};
         do_run($sformatf("rand %0d", k), l, m, a, n, p, 0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule